// File: doc/BRIEF.md
# PCI Type 1 Configuration Routing Decoder

This block sits beside the address-phase logic of a two-port PCI-to-PCI bridge and decides, for every sampled address phase, what the bridge does with a configuration cycle. It reads the multiplexed address/data bus, the command nibble, a flag that tells which side of the bridge the transaction was seen on, and the bridge's secondary and subordinate bus numbers. From these it selects one routing decision and holds it until the next address phase. The decisions are: pass a Type 1 access on unchanged towards the secondary side, turn it into a Type 0 access on the secondary bus, pass a Type 1 configuration write upstream so that a special cycle can be generated further up, ignore a special cycle, or leave the transaction unclaimed.

The decision lives in a small state machine. Its states are `ST_IDLE` (after reset, nothing decided), `ST_DOWN`, `ST_TYPE0`, `ST_UP`, `ST_IGNORE` and `ST_NOCLAIM`. There are two kinds of transition. On any cycle with the address-phase strobe high, every state moves to the state the route picker selects (the "sample" transition, which may return to the same state). Without the strobe, every state stays where it is (the "hold" transition). A synchronous reset moves any state to `ST_IDLE`. Each of the three forwarding states also raises a flag that marks the forwarded access as a delayed transaction limited to one 32-bit data phase.

Top module: `cfg_route_decoder`

## Requirements
- R1: While reset is high, and in the cycle after it falls with no strobe, all six outputs are low (state `ST_IDLE`).
- R2: The outputs change only on the clock edge after a cycle with `addr_phase` high. Without the strobe they keep their value, whatever the other inputs do.
- R3: A strobed address phase with command 4'b0001 (special cycle) gives `route_ignore`, on either side and for any address.
- R4: On the primary side (`from_secondary`=0), with `ad[1:0]`=2'b01, command 4'b1010 (config read) or 4'b1011 (config write), and bus number `ad[23:16]` strictly above `sec_bus_num` and not above `sub_bus_num`, the decision is `route_down`.
- R5: On the primary side, with `ad[1:0]`=2'b01, a config read or write command, and bus number equal to `sec_bus_num`, the decision is `route_type0`.
- R6: On the secondary side, with `ad[1:0]`=2'b01, command 4'b1011, device field `ad[15:11]`=5'b11111, function field `ad[10:8]`=3'b111, and bus number below `sec_bus_num` or above `sub_bus_num`, the decision is `route_up`.
- R7: Any strobed address phase that matches none of R3 to R6 gives `route_unclaimed`. This covers `ad[1:0]` other than 2'b01, other commands, a config read on the secondary side, a partial device or function pattern, and bus numbers outside the tested window.
- R8: After every strobed address phase, exactly one of the five route outputs is high.
- R9: `delayed_single` is high exactly when `route_down`, `route_type0` or `route_up` is high.
- R10: The rules for the secondary side (R4, R5) apply only when `from_secondary`=0, and the upstream rule (R6) applies only when `from_secondary`=1. A matching pattern seen on the other side is unclaimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_phase | input | 1 | High for one cycle when the address phase is valid |
| ad | input | 32 | Address/data bus during the address phase |
| cbe_cmd | input | 4 | Bus command nibble |
| from_secondary | input | 1 | 1: transaction seen on the secondary side; 0: primary side |
| sec_bus_num | input | 8 | Secondary bus number register |
| sub_bus_num | input | 8 | Subordinate bus number register |
| route_down | output | 1 | Forward Type 1 unchanged to the secondary bus |
| route_type0 | output | 1 | Convert to Type 0 on the secondary bus |
| route_up | output | 1 | Forward Type 1 configuration write upstream |
| route_ignore | output | 1 | Special cycle is ignored and not forwarded |
| route_unclaimed | output | 1 | No rule matched |
| delayed_single | output | 1 | Forwarded access is delayed, with a single data phase |

## Verification
On every cycle, the assertions check a few things: the outputs hold without a strobe, exactly one route is high after a sample, special cycles always give ignore, accesses that are not Type 1 end unclaimed, each forwarding direction stays on its own side, and the delayed flag agrees with the forwarding outputs. Only the bench's scenarios can show that the bus-window edges are decided correctly. These edges are the exclusive lower bound downstream against the inclusive one upstream, a bus number equal to the secondary number, and equal secondary and subordinate numbers. The bench also shows the need for the full all-ones device and function pattern, and the behaviour across a reset in the middle of a run.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DOWN    = 3'd1,
        ST_TYPE0   = 3'd2,
        ST_UP      = 3'd3,
        ST_IGNORE  = 3'd4,
        ST_NOCLAIM = 3'd5
    } route_st_e;

    localparam logic [3:0] CMD_SPECIAL = 4'b0001;
    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [1:0] TYPE1_CODE  = 2'b01;

endpackage

// File: rtl/cfg_addr_split.sv
module cfg_addr_split #(
    parameter int AW      = 32,
    parameter int BUS_W   = 8,
    parameter int BUS_LSB = 16,
    parameter int DEV_W   = 5,
    parameter int DEV_LSB = 11,
    parameter int FN_W    = 3,
    parameter int FN_LSB  = 8
) (
    input  logic [AW-1:0]    ad,
    output logic             is_type1,
    output logic [BUS_W-1:0] bus_num,
    output logic             devfn_all1
);
    import cfg_route_pkg::*;

    logic [DEV_W-1:0] dev_f;
    logic [FN_W-1:0]  fn_f;

    always_comb begin
        is_type1   = (ad[1:0] == TYPE1_CODE);
        bus_num    = ad[BUS_LSB +: BUS_W];
        dev_f      = ad[DEV_LSB +: DEV_W];
        fn_f       = ad[FN_LSB +: FN_W];
        devfn_all1 = (&dev_f) && (&fn_f);
    end
endmodule

// File: rtl/cfg_bus_window.sv
module cfg_bus_window #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus_num,
    input  logic [BUS_W-1:0] sec_num,
    input  logic [BUS_W-1:0] sub_num,
    output logic             hit_sec,
    output logic             below_sub_excl,
    output logic             inside_incl
);
    always_comb begin
        hit_sec        = (bus_num == sec_num);
        below_sub_excl = (bus_num > sec_num) && (bus_num <= sub_num);
        inside_incl    = (bus_num >= sec_num) && (bus_num <= sub_num);
    end
endmodule

// File: rtl/cfg_route_pick.sv
module cfg_route_pick (
    input  logic                      is_type1,
    input  logic [3:0]                cmd,
    input  logic                      from_sec,
    input  logic                      devfn_all1,
    input  logic                      hit_sec,
    input  logic                      below_sub_excl,
    input  logic                      inside_incl,
    output cfg_route_pkg::route_st_e  pick
);
    import cfg_route_pkg::*;

    logic is_cfg;

    always_comb begin
        is_cfg = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
        pick   = ST_NOCLAIM;
        if (cmd == CMD_SPECIAL) begin
            pick = ST_IGNORE;
        end else if (is_type1) begin
            if (!from_sec) begin
                if (is_cfg && hit_sec)             pick = ST_TYPE0;
                else if (is_cfg && below_sub_excl) pick = ST_DOWN;
            end else begin
                if ((cmd == CMD_CFG_WR) && devfn_all1 && !inside_incl)
                    pick = ST_UP;
            end
        end
    end
endmodule

// File: rtl/cfg_route_decoder.sv
module cfg_route_decoder #(
    parameter int AW    = 32,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_phase,
    input  logic [AW-1:0]    ad,
    input  logic [3:0]       cbe_cmd,
    input  logic             from_secondary,
    input  logic [BUS_W-1:0] sec_bus_num,
    input  logic [BUS_W-1:0] sub_bus_num,
    output logic             route_down,
    output logic             route_type0,
    output logic             route_up,
    output logic             route_ignore,
    output logic             route_unclaimed,
    output logic             delayed_single
);
    import cfg_route_pkg::*;

    logic             is_type1;
    logic [BUS_W-1:0] bus_num;
    logic             devfn_all1;
    logic             hit_sec, below_sub_excl, inside_incl;
    route_st_e        pick, state_q;

    cfg_addr_split #(.AW(AW), .BUS_W(BUS_W)) u_split (
        .ad         (ad),
        .is_type1   (is_type1),
        .bus_num    (bus_num),
        .devfn_all1 (devfn_all1)
    );

    cfg_bus_window #(.BUS_W(BUS_W)) u_window (
        .bus_num        (bus_num),
        .sec_num        (sec_bus_num),
        .sub_num        (sub_bus_num),
        .hit_sec        (hit_sec),
        .below_sub_excl (below_sub_excl),
        .inside_incl    (inside_incl)
    );

    cfg_route_pick u_pick (
        .is_type1       (is_type1),
        .cmd            (cbe_cmd),
        .from_sec       (from_secondary),
        .devfn_all1     (devfn_all1),
        .hit_sec        (hit_sec),
        .below_sub_excl (below_sub_excl),
        .inside_incl    (inside_incl),
        .pick           (pick)
    );

    // State register: sample on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (rst)             state_q <= ST_IDLE;
        else if (addr_phase) state_q <= pick;
    end

    // Output decode from the held state.
    always_comb begin
        route_down      = 1'b0;
        route_type0     = 1'b0;
        route_up        = 1'b0;
        route_ignore    = 1'b0;
        route_unclaimed = 1'b0;
        delayed_single  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_DOWN:    begin route_down  = 1'b1; delayed_single = 1'b1; end
            ST_TYPE0:   begin route_type0 = 1'b1; delayed_single = 1'b1; end
            ST_UP:      begin route_up    = 1'b1; delayed_single = 1'b1; end
            ST_IGNORE:  route_ignore    = 1'b1;
            ST_NOCLAIM: route_unclaimed = 1'b1;
            default:    ;
        endcase
    end

    logic [4:0] routes;
    assign routes = {route_down, route_type0, route_up, route_ignore, route_unclaimed};

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (routes == 5'b0 && !delayed_single));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !addr_phase |=> ($stable(routes) && $stable(delayed_single)));

    p_special_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && cbe_cmd == CMD_SPECIAL) |=> route_ignore);

    p_not_type1_r7: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && ad[1:0] != TYPE1_CODE && cbe_cmd != CMD_SPECIAL) |=> route_unclaimed);

    p_one_route_r8: assert property (@(posedge clk) disable iff (rst)
        addr_phase |=> ($countones(routes) == 1));

    p_delayed_flag_r9: assert property (@(posedge clk) disable iff (rst)
        delayed_single == (route_down || route_type0 || route_up));

    p_primary_no_up_r10: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && !from_secondary) |=> !route_up);

    p_secondary_no_down_r10: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && from_secondary) |=> (!route_down && !route_type0));

endmodule

// File: tb/cfg_route_decoder_tb.sv
module cfg_route_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        addr_phase;
    logic [31:0] ad;
    logic [3:0]  cbe_cmd;
    logic        from_secondary;
    logic [7:0]  sec_bus_num, sub_bus_num;
    logic        route_down, route_type0, route_up, route_ignore, route_unclaimed, delayed_single;

    always #2 clk = ~clk;   // 250 MHz

    cfg_route_decoder dut_i (
        .clk(clk), .rst(rst), .addr_phase(addr_phase), .ad(ad), .cbe_cmd(cbe_cmd),
        .from_secondary(from_secondary), .sec_bus_num(sec_bus_num), .sub_bus_num(sub_bus_num),
        .route_down(route_down), .route_type0(route_type0), .route_up(route_up),
        .route_ignore(route_ignore), .route_unclaimed(route_unclaimed),
        .delayed_single(delayed_single)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    running = 1'b0;
    bit    done = 1'b0;
    string lbl = "R1";
    // expected {down, type0, up, ignore, unclaimed}
    logic [4:0] exp_r = 5'b0;

    // Behavioural reference: returns the expected route bits.
    function automatic logic [4:0] ref_route(logic [31:0] a, logic [3:0] c, logic sec_side,
                                             int sec, int sub);
        int bus;
        bus = int'(a[23:16]);
        if (c == 4'b0001) return 5'b00010;
        if (a[1:0] != 2'b01) return 5'b00001;
        if (!sec_side) begin
            if (c != 4'b1010 && c != 4'b1011) return 5'b00001;
            if (bus == sec) return 5'b01000;
            if (bus > sec && bus <= sub) return 5'b10000;
            return 5'b00001;
        end
        if (c == 4'b1011 && a[15:11] == 5'b11111 && a[10:8] == 3'b111 &&
            (bus < sec || bus > sub)) return 5'b00100;
        return 5'b00001;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) exp_r = 5'b0;
        else if (addr_phase)
            exp_r = ref_route(ad, cbe_cmd, from_secondary, int'(sec_bus_num), int'(sub_bus_num));
    end

    always @(negedge clk) begin
        if (running && !done) begin
            logic [5:0] got, want;
            got  = {route_down, route_type0, route_up, route_ignore, route_unclaimed, delayed_single};
            want = {exp_r, |exp_r[4:2]};
            n_vec++;
            if (got !== want) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b (down,type0,up,ign,unclm,dly)", lbl, got, want);
            end
        end
    end

    task automatic strobe(input logic [31:0] a, input logic [3:0] c, input logic s, input string l);
        @(negedge clk);
        lbl = l; ad = a; cbe_cmd = c; from_secondary = s; addr_phase = 1'b1;
        @(negedge clk);
        // hold cycle with disturbing inputs (R2)
        addr_phase = 1'b0; ad = ~a; cbe_cmd = 4'b1010; from_secondary = ~s;
    endtask

    function automatic logic [31:0] mk(int bus, int dev, int fn, int low);
        return {8'h00, 8'(bus), 5'(dev), 3'(fn), 6'h2A, 2'(low)};
    endfunction

    initial begin
        rst = 1'b1; addr_phase = 1'b0; ad = '0; cbe_cmd = 4'b0; from_secondary = 1'b0;
        sec_bus_num = 8'd5; sub_bus_num = 8'd9;
        running = 1'b1;
        repeat (3) @(negedge clk);
        lbl = "R1";
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Downstream window edges (R4), convert (R5)
        strobe(mk(6, 3, 1, 1), 4'b1010, 1'b0, "R4");
        strobe(mk(9, 3, 1, 1), 4'b1011, 1'b0, "R4");
        strobe(mk(5, 3, 1, 1), 4'b1010, 1'b0, "R5");
        strobe(mk(5, 0, 0, 1), 4'b1011, 1'b0, "R5");
        strobe(mk(10, 3, 1, 1), 4'b1010, 1'b0, "R7");
        strobe(mk(4, 3, 1, 1), 4'b1011, 1'b0, "R7");
        strobe(mk(7, 3, 1, 0), 4'b1010, 1'b0, "R7");
        strobe(mk(7, 3, 1, 1), 4'b0110, 1'b0, "R7");
        // Special cycles (R3)
        strobe(mk(7, 31, 7, 1), 4'b0001, 1'b0, "R3");
        strobe(mk(2, 31, 7, 3), 4'b0001, 1'b1, "R3");
        // Upstream (R6) and its edges
        strobe(mk(4, 31, 7, 1), 4'b1011, 1'b1, "R6");
        strobe(mk(10, 31, 7, 1), 4'b1011, 1'b1, "R6");
        strobe(mk(5, 31, 7, 1), 4'b1011, 1'b1, "R7");
        strobe(mk(9, 31, 7, 1), 4'b1011, 1'b1, "R7");
        strobe(mk(4, 31, 7, 1), 4'b1010, 1'b1, "R7");
        strobe(mk(4, 30, 7, 1), 4'b1011, 1'b1, "R7");
        strobe(mk(4, 31, 6, 1), 4'b1011, 1'b1, "R7");
        // Side selection (R10)
        strobe(mk(7, 3, 1, 1), 4'b1010, 1'b1, "R10");
        strobe(mk(5, 3, 1, 1), 4'b1011, 1'b1, "R10");
        strobe(mk(200, 31, 7, 1), 4'b1011, 1'b0, "R10");
        // Equal sec/sub numbers
        sec_bus_num = 8'd12; sub_bus_num = 8'd12;
        strobe(mk(12, 1, 0, 1), 4'b1010, 1'b0, "R5");
        strobe(mk(13, 1, 0, 1), 4'b1010, 1'b0, "R7");
        strobe(mk(13, 31, 7, 1), 4'b1011, 1'b1, "R6");
        strobe(mk(12, 31, 7, 1), 4'b1011, 1'b1, "R7");

        // Reset in the middle of a run (R1)
        @(negedge clk); lbl = "R1"; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);

        // Mixed traffic with boundary-biased bus numbers (R8, R9, R2)
        sec_bus_num = 8'd20; sub_bus_num = 8'd40;
        for (int i = 0; i < 400; i++) begin
            logic [3:0] cmds [4];
            int picks [6];
            cmds[0] = 4'b1010; cmds[1] = 4'b1011; cmds[2] = 4'b0001; cmds[3] = 4'($urandom);
            picks[0] = 19; picks[1] = 20; picks[2] = 21; picks[3] = 40; picks[4] = 41;
            picks[5] = int'($urandom_range(0, 255));
            @(negedge clk);
            lbl = "R8";
            addr_phase = ($urandom_range(0, 2) != 0);
            cbe_cmd = cmds[$urandom_range(0, 3)];
            from_secondary = 1'($urandom);
            ad = mk(picks[$urandom_range(0, 5)],
                    ($urandom_range(0, 1) != 0) ? 31 : int'($urandom_range(0, 31)),
                    ($urandom_range(0, 1) != 0) ? 7 : int'($urandom_range(0, 7)),
                    ($urandom_range(0, 3) != 0) ? 1 : int'($urandom_range(0, 3)));
        end
        @(negedge clk); addr_phase = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule